// File: doc/BRIEF.md
# Tunneled JTAG Debug Transport

This block sits behind one user scan chain that a device's fixed boundary-scan controller exposes to fabric logic. It has no TAP state machine of its own. Instead, every shift of that user chain carries a self-describing frame, and a nested 6-bit instruction register inside the frame picks which of the block's own data registers is read and written. A host debugger first selects the user chain with the outer instruction register. It then shifts a frame whose leading field loads the nested instruction register. Finally it shifts further frames that read and write the data register that nested value selects. Behind these registers sits a RISC-V debug transport: an identification register, a transport control/status register and a 41-bit debug-module access register that issues requests to a debug module and collects its responses.

A frame is shifted least significant bit first. Bits 0 to 5 hold the nested instruction. Bits 6 to 6+L-1 hold an L-bit payload. The last 7 bits hold L. The readback of the register selected at capture time leaves on the serial output in the payload bit positions. All logic runs on the user-chain test clock. It is cleared only by its own debug reset, never by the CPU reset, which the block drives from the debug module's non-debug reset request.

Top module: `jtun_dtm`

## Requirements
- R1: A frame on the selected chain is accepted at update only when the number of bits shifted since capture equals 13 plus the 7-bit length field L found in the last 7 bits, and L is at most 41. An accepted frame loads its 6-bit instruction field (bits 0..5) into the nested instruction register. During the shift, serial-out bit 6+k is bit k of the register that the nested instruction held at capture selects.
- R2: Nested code 0x01 selects a 32-bit identification register that holds the IDCODE parameter. Code 0x10 selects the control/status register and 0x11 the access register. Code 0x3F and every other code select a 1-bit register that reads 0.
- R3: The control/status register reads version 1 in bits 3:0, address width 7 in bits 9:4, sticky status in bits 11:10 and idle hint 7 in bits 14:12, with all other bits 0. Its value with clear status is 0x7071.
- R4: A frame whose length field disagrees with the number of bits shifted changes neither the nested instruction register nor any data register.
- R5: Only select bit CHAIN_ID-1 (default chain 4, bit 3) enables the block. Frames shifted on any other chain are ignored.
- R6: An accepted 41-bit access frame with op (bits 1:0) equal to 1 (read) or 2 (write) issues a request with address bits 40:34, data bits 33:2 and that op. The request is held stable until the ready input is seen high.
- R7: Capturing the access register loads {last request address, last response data, status}. While a request is outstanding the status is 3, and this also sets the sticky status to 3.
- R8: Writing control/status bit 16 clears the sticky status. Writing bit 17 clears it and also cancels any outstanding or pending request.
- R9: A response with nonzero status sets the sticky status to 2. While the sticky status is nonzero, or a request is outstanding, new read or write ops issue no request.
- R10: The outer test-logic reset input returns the nested instruction register to 0x01, as does the debug reset.
- R11: The CPU reset output goes low one clock after the non-debug reset request goes high and goes high one clock after it falls. Debug state is kept throughout.
- R12: An accepted frame for the control/status or access register whose length is not 32 or 41 respectively updates the nested instruction register but writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | User-chain test clock |
| rst_n | input | 1 | Debug reset, asynchronous active low |
| usr_sel_vec | input | NUM_CHAINS | One select per user chain |
| usr_capture | input | 1 | Capture phase of the user chain |
| usr_shift | input | 1 | Shift phase of the user chain |
| usr_update | input | 1 | Update phase of the user chain |
| usr_reset | input | 1 | Outer test-logic reset |
| usr_tdi | input | 1 | Serial data in |
| usr_tdo | output | 1 | Serial data out |
| dmi_req_valid | output | 1 | Debug-module request valid |
| dmi_req_ready | input | 1 | Debug module accepts the request |
| dmi_req_addr | output | 7 | Request address |
| dmi_req_data | output | 32 | Request write data |
| dmi_req_op | output | 2 | Request op, 1 read, 2 write |
| dmi_rsp_valid | input | 1 | Response strobe |
| dmi_rsp_data | input | 32 | Response data |
| dmi_rsp_status | input | 2 | Response status, 0 good |
| ndm_reset_req | input | 1 | Non-debug reset request |
| cpu_rst_n | output | 1 | CPU reset, active low |

## Verification
The hardest state to reach is a busy access register. A read must be accepted by the debug module while its response is held back, and only then is the access register captured again, so that status 3 appears and sticks. The bench builds this from frames alone. It then shows that a control/status hard-reset frame clears both the sticky status and the outstanding request, and that a late response arriving afterward changes nothing. A second sequence forces an error response and shows that requests stay blocked until the status is cleared.

// File: rtl/jtun_pkg.sv
package jtun_pkg;
  localparam int IRW     = 6;
  localparam int ABITS   = 7;
  localparam int DATAW   = 32;
  localparam int OPW     = 2;
  localparam int DMI_W   = ABITS + DATAW + OPW;
  localparam int LENW    = 7;
  localparam int FRAME_W = IRW + DMI_W + LENW;
  localparam int CNTW    = 7;
  localparam int CSR_W   = 32;

  localparam logic [IRW-1:0] IR_IDCODE = 6'h01;
  localparam logic [IRW-1:0] IR_DTMCS  = 6'h10;
  localparam logic [IRW-1:0] IR_DMI    = 6'h11;

  localparam logic [OPW-1:0] OP_READ  = 2'd1;
  localparam logic [OPW-1:0] OP_WRITE = 2'd2;
  localparam logic [1:0]     ST_ERR   = 2'd2;
  localparam logic [1:0]     ST_BUSY  = 2'd3;
endpackage

// File: rtl/jtun_frame_rx.sv
module jtun_frame_rx
  import jtun_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             capture,
  input  logic             shift,
  input  logic             tdi,
  output logic             frame_ok,
  output logic [IRW-1:0]   f_ir,
  output logic [LENW-1:0]  f_len,
  output logic [DMI_W-1:0] f_payload
);
  logic [CNTW-1:0]    cnt_q, cnt_d;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic [LENW-1:0]    tail_q, tail_d;
  logic [DMI_W-1:0]   len_mask;

  always_comb begin
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tail_d = tail_q;
    if (sel && capture) begin
      cnt_d = '0;
    end else if (sel && shift) begin
      if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
      for (int i = 0; i < FRAME_W; i++) begin
        if (cnt_q == CNTW'(i)) rx_d[i] = tdi;
      end
      tail_d = {tdi, tail_q[LENW-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      tail_q <= '0;
    end else if (sel) begin
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tail_q <= tail_d;
    end
  end

  always_comb begin
    len_mask  = (tail_q == '0) ? '0 : ({DMI_W{1'b1}} >> (DMI_W - int'(tail_q)));
    f_ir      = rx_q[IRW-1:0];
    f_len     = tail_q;
    f_payload = rx_q[IRW +: DMI_W] & len_mask;
    frame_ok  = (tail_q <= LENW'(DMI_W)) &&
                ({1'b0, cnt_q} == (8'(IRW + LENW) + {1'b0, tail_q}));
  end
endmodule

// File: rtl/jtun_tx.sv
module jtun_tx
  import jtun_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             capture,
  input  logic             shift,
  input  logic [DMI_W-1:0] cap_value,
  output logic             tdo
);
  logic [FRAME_W-1:0] tx_q, tx_d;

  always_comb begin
    tx_d = tx_q;
    if (sel && capture)    tx_d = FRAME_W'(cap_value) << IRW;
    else if (sel && shift) tx_d = tx_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tx_q <= '0;
    else if (sel) tx_q <= tx_d;
  end

  assign tdo = tx_q[0];
endmodule

// File: rtl/jtun_regs.sv
module jtun_regs
  import jtun_pkg::*;
#(
  parameter logic [31:0] IDCODE    = 32'h1BEE_F0DB,
  parameter int          IDLE_HINT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             capture,
  input  logic             update,
  input  logic             tap_reset,
  input  logic             frame_ok,
  input  logic [IRW-1:0]   f_ir,
  input  logic [LENW-1:0]  f_len,
  input  logic [DMI_W-1:0] f_payload,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic [DATAW-1:0] rsp_data,
  input  logic [1:0]       rsp_status,
  output logic             req_valid,
  output logic [ABITS-1:0] req_addr,
  output logic [DATAW-1:0] req_data,
  output logic [OPW-1:0]   req_op,
  output logic [DMI_W-1:0] cap_value,
  output logic [IRW-1:0]   ir_o
);
  logic [IRW-1:0]   ir_q, ir_d;
  logic [1:0]       sticky_q, sticky_d;
  logic             pend_q, pend_d;
  logic             reqv_q, reqv_d;
  logic [ABITS-1:0] addr_q, addr_d;
  logic [DATAW-1:0] wdat_q, wdat_d;
  logic [OPW-1:0]   op_q, op_d;
  logic [DATAW-1:0] rdat_q, rdat_d;
  logic             upd_ok;
  logic [OPW-1:0]   f_op;
  logic [CSR_W-1:0] csr_val;

  assign upd_ok = sel && update && frame_ok;
  assign f_op   = f_payload[OPW-1:0];

  always_comb begin
    ir_d     = ir_q;
    sticky_d = sticky_q;
    pend_d   = pend_q;
    reqv_d   = reqv_q;
    addr_d   = addr_q;
    wdat_d   = wdat_q;
    op_d     = op_q;
    rdat_d   = rdat_q;

    if (reqv_q && req_ready) reqv_d = 1'b0;

    if (rsp_valid && pend_q && !reqv_q) begin
      pend_d = 1'b0;
      rdat_d = rsp_data;
      if (rsp_status != 2'd0 && sticky_q == 2'd0) sticky_d = ST_ERR;
    end

    if (sel && capture && ir_q == IR_DMI && pend_q) sticky_d = ST_BUSY;

    if (upd_ok) begin
      ir_d = f_ir;
      if (f_ir == IR_DTMCS && f_len == LENW'(CSR_W)) begin
        if (f_payload[17]) begin
          sticky_d = 2'd0;
          pend_d   = 1'b0;
          reqv_d   = 1'b0;
        end else if (f_payload[16]) begin
          sticky_d = 2'd0;
        end
      end
      if (f_ir == IR_DMI && f_len == LENW'(DMI_W) &&
          (f_op == OP_READ || f_op == OP_WRITE)) begin
        if (pend_q) begin
          sticky_d = ST_BUSY;
        end else if (sticky_q == 2'd0) begin
          reqv_d = 1'b1;
          pend_d = 1'b1;
          op_d   = f_op;
          wdat_d = f_payload[OPW +: DATAW];
          addr_d = f_payload[OPW+DATAW +: ABITS];
        end
      end
    end

    if (tap_reset) ir_d = IR_IDCODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q     <= IR_IDCODE;
      sticky_q <= '0;
      pend_q   <= 1'b0;
      reqv_q   <= 1'b0;
      addr_q   <= '0;
      wdat_q   <= '0;
      op_q     <= '0;
      rdat_q   <= '0;
    end else begin
      ir_q     <= ir_d;
      sticky_q <= sticky_d;
      pend_q   <= pend_d;
      reqv_q   <= reqv_d;
      addr_q   <= addr_d;
      wdat_q   <= wdat_d;
      op_q     <= op_d;
      rdat_q   <= rdat_d;
    end
  end

  always_comb begin
    csr_val        = '0;
    csr_val[3:0]   = 4'd1;
    csr_val[9:4]   = 6'(ABITS);
    csr_val[11:10] = sticky_q;
    csr_val[14:12] = 3'(IDLE_HINT);
    case (ir_q)
      IR_IDCODE: cap_value = DMI_W'(IDCODE);
      IR_DTMCS:  cap_value = DMI_W'(csr_val);
      IR_DMI:    cap_value = {addr_q, rdat_q, (pend_q ? ST_BUSY : sticky_q)};
      default:   cap_value = '0;
    endcase
  end

  assign req_valid = reqv_q;
  assign req_addr  = addr_q;
  assign req_data  = wdat_q;
  assign req_op    = op_q;
  assign ir_o      = ir_q;
endmodule

// File: rtl/jtun_dtm.sv
module jtun_dtm
  import jtun_pkg::*;
#(
  parameter int          NUM_CHAINS = 4,
  parameter int          CHAIN_ID   = 4,
  parameter logic [31:0] IDCODE     = 32'h1BEE_F0DB,
  parameter int          IDLE_HINT  = 7
) (
  input  logic                  tck,
  input  logic                  rst_n,
  input  logic [NUM_CHAINS-1:0] usr_sel_vec,
  input  logic                  usr_capture,
  input  logic                  usr_shift,
  input  logic                  usr_update,
  input  logic                  usr_reset,
  input  logic                  usr_tdi,
  output logic                  usr_tdo,
  output logic                  dmi_req_valid,
  input  logic                  dmi_req_ready,
  output logic [6:0]            dmi_req_addr,
  output logic [31:0]           dmi_req_data,
  output logic [1:0]            dmi_req_op,
  input  logic                  dmi_rsp_valid,
  input  logic [31:0]           dmi_rsp_data,
  input  logic [1:0]            dmi_rsp_status,
  input  logic                  ndm_reset_req,
  output logic                  cpu_rst_n
);
  localparam int SEL_IDX = CHAIN_ID - 1;

  logic [1:0]       rst_sync_q;
  logic             dbg_rst_n;
  logic             sel;
  logic             frame_ok;
  logic [IRW-1:0]   f_ir;
  logic [LENW-1:0]  f_len;
  logic [DMI_W-1:0] f_payload;
  logic [DMI_W-1:0] cap_value;
  logic [IRW-1:0]   nested_ir;
  logic             cpu_rst_q, cpu_rst_d;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign dbg_rst_n = rst_sync_q[1];

  assign sel = usr_sel_vec[SEL_IDX];

  jtun_frame_rx u_rx (
    .clk(tck), .rst_n(dbg_rst_n), .sel(sel), .capture(usr_capture),
    .shift(usr_shift), .tdi(usr_tdi), .frame_ok(frame_ok), .f_ir(f_ir),
    .f_len(f_len), .f_payload(f_payload)
  );

  jtun_regs #(.IDCODE(IDCODE), .IDLE_HINT(IDLE_HINT)) u_regs (
    .clk(tck), .rst_n(dbg_rst_n), .sel(sel), .capture(usr_capture),
    .update(usr_update), .tap_reset(usr_reset), .frame_ok(frame_ok),
    .f_ir(f_ir), .f_len(f_len), .f_payload(f_payload),
    .req_ready(dmi_req_ready), .rsp_valid(dmi_rsp_valid),
    .rsp_data(dmi_rsp_data), .rsp_status(dmi_rsp_status),
    .req_valid(dmi_req_valid), .req_addr(dmi_req_addr),
    .req_data(dmi_req_data), .req_op(dmi_req_op),
    .cap_value(cap_value), .ir_o(nested_ir)
  );

  jtun_tx u_tx (
    .clk(tck), .rst_n(dbg_rst_n), .sel(sel), .capture(usr_capture),
    .shift(usr_shift), .cap_value(cap_value), .tdo(usr_tdo)
  );

  assign cpu_rst_d = ~ndm_reset_req;
  always_ff @(posedge tck or negedge dbg_rst_n) begin
    if (!dbg_rst_n) cpu_rst_q <= 1'b1;
    else            cpu_rst_q <= cpu_rst_d;
  end
  assign cpu_rst_n = cpu_rst_q;
endmodule

// File: rtl/jtun_dtm_chk.sv
module jtun_dtm_chk #(
  parameter int NUM_CHAINS = 4,
  parameter int CHAIN_ID   = 4
) (
  input logic                  clk,
  input logic                  dbg_rst_n,
  input logic [NUM_CHAINS-1:0] usr_sel_vec,
  input logic                  usr_update,
  input logic                  usr_reset,
  input logic                  dmi_req_valid,
  input logic                  dmi_req_ready,
  input logic [6:0]            dmi_req_addr,
  input logic [31:0]           dmi_req_data,
  input logic [1:0]            dmi_req_op,
  input logic                  ndm_reset_req,
  input logic                  cpu_rst_n,
  input logic [5:0]            nested_ir
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    (dmi_req_valid && !dmi_req_ready && !usr_update) |=>
      (dmi_req_valid && $stable(dmi_req_addr) && $stable(dmi_req_data) && $stable(dmi_req_op)));

  // R5
  req_src_chk: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    $rose(dmi_req_valid) |-> $past(usr_update && usr_sel_vec[CHAIN_ID-1]));

  // R10
  tap_reset_chk: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    usr_reset |=> (nested_ir == 6'h01));

  // R11
  cpu_rst_low_chk: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    ndm_reset_req |=> !cpu_rst_n);

  // R11
  cpu_rst_high_chk: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    !ndm_reset_req |=> cpu_rst_n);
endmodule

bind jtun_dtm jtun_dtm_chk #(.NUM_CHAINS(NUM_CHAINS), .CHAIN_ID(CHAIN_ID)) u_chk (
  .clk(tck), .dbg_rst_n(dbg_rst_n), .usr_sel_vec(usr_sel_vec),
  .usr_update(usr_update), .usr_reset(usr_reset),
  .dmi_req_valid(dmi_req_valid), .dmi_req_ready(dmi_req_ready),
  .dmi_req_addr(dmi_req_addr), .dmi_req_data(dmi_req_data),
  .dmi_req_op(dmi_req_op), .ndm_reset_req(ndm_reset_req),
  .cpu_rst_n(cpu_rst_n), .nested_ir(nested_ir)
);

// File: tb/jtun_dtm_tb.sv
module jtun_dtm_tb;
  localparam logic [31:0] ID = 32'h1BEE_F0DB;
  localparam int NV = 6;
  localparam logic [5:0]  T_IR [NV] = '{6'h01, 6'h10, 6'h11, 6'h3F, 6'h05, 6'h00};
  localparam int          T_W  [NV] = '{32, 32, 41, 1, 1, 1};
  localparam logic [40:0] T_EXP[NV] = '{41'(ID), 41'h7071, 41'h0, 41'h0, 41'h0, 41'h0};

  logic tck = 1'b0;
  logic rst_n, usr_capture, usr_shift, usr_update, usr_reset, usr_tdi, usr_tdo;
  logic [3:0] usr_sel_vec;
  logic dmi_req_valid, dmi_req_ready, dmi_rsp_valid, ndm_reset_req, cpu_rst_n;
  logic [6:0] dmi_req_addr;
  logic [31:0] dmi_req_data, dmi_rsp_data;
  logic [1:0] dmi_req_op, dmi_rsp_status;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [40:0] rd;

  always #2 tck = ~tck;

  jtun_dtm u_dut (.*);

  task automatic chk(input string req, input logic [40:0] act, input logic [40:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [5:0] ins, input int len, input logic [6:0] lenf,
                       input logic [40:0] pay, input int chain, output logic [40:0] rdo);
    int n = 13 + len;
    rdo = '0;
    usr_sel_vec = 4'(1 << (chain - 1));
    usr_capture = 1'b1;
    @(posedge tck); @(negedge tck);
    usr_capture = 1'b0;
    usr_shift = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (i < 6)            usr_tdi = ins[i];
      else if (i < 6 + len) usr_tdi = pay[i-6];
      else                  usr_tdi = lenf[i-6-len];
      if (i >= 6 && i < 6 + len && i - 6 < 41) rdo[i-6] = usr_tdo;
      @(posedge tck); @(negedge tck);
    end
    usr_shift = 1'b0;
    usr_update = 1'b1;
    @(posedge tck); @(negedge tck);
    usr_update = 1'b0;
    usr_sel_vec = '0;
  endtask

  task automatic fr(input logic [5:0] ins, input int len, input logic [40:0] pay,
                    output logic [40:0] rdo);
    frame(ins, len, 7'(len), pay, 4, rdo);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge tck); @(negedge tck); end
  endtask

  function automatic logic [40:0] dmi(input logic [6:0] a, input logic [31:0] d, input logic [1:0] o);
    return {a, d, o};
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; usr_sel_vec = '0; usr_capture = 0; usr_shift = 0; usr_update = 0;
    usr_reset = 0; usr_tdi = 0; dmi_req_ready = 0; dmi_rsp_valid = 0;
    dmi_rsp_data = '0; dmi_rsp_status = '0; ndm_reset_req = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    chk("R11 reset cpu_rst_n", 41'(cpu_rst_n), 41'd1);
    chk("R6 reset req_valid", 41'(dmi_req_valid), 41'd0);

    // R1 R2 R3 table walk; first capture after reset reads IDCODE (R10)
    for (int v = 0; v < NV; v++) begin
      fr(T_IR[v], T_W[v], '0, rd);
      if (v == 0) chk("R10 reset IR idcode", rd & 41'hFFFFFFFF, 41'(ID));
      fr(T_IR[v], T_W[v], '0, rd);
      chk("R2 R3 table readback", rd & ((41'd1 << T_W[v]) - 1), T_EXP[v]);
    end

    // R6 write request held until ready
    fr(6'h11, 41, dmi(7'h10, 32'h0000A5A5, 2'd2), rd);
    chk("R6 req issued", {dmi_req_valid, dmi_req_addr, dmi_req_data, dmi_req_op},
        {1'b1, 7'h10, 32'h0000A5A5, 2'd2});
    cyc(3);
    chk("R6 req held", 41'(dmi_req_valid), 41'd1);
    dmi_req_ready = 1; cyc(1); dmi_req_ready = 0;
    chk("R6 req dropped", 41'(dmi_req_valid), 41'd0);
    dmi_rsp_valid = 1; dmi_rsp_data = 32'hCAFEF00D; cyc(1); dmi_rsp_valid = 0;
    fr(6'h11, 41, '0, rd);
    chk("R7 dmi capture", rd, dmi(7'h10, 32'hCAFEF00D, 2'd0));

    // R7 busy then R8 hard reset
    fr(6'h11, 41, dmi(7'h05, 32'h0, 2'd1), rd);
    dmi_req_ready = 1; cyc(1); dmi_req_ready = 0;
    fr(6'h11, 41, '0, rd);
    chk("R7 busy status", rd, dmi(7'h05, 32'hCAFEF00D, 2'd3));
    fr(6'h11, 41, dmi(7'h06, 32'h1, 2'd2), rd);
    chk("R9 no req while busy", 41'(dmi_req_valid), 41'd0);
    fr(6'h10, 32, 41'(1 << 17), rd);
    fr(6'h10, 32, '0, rd);
    chk("R8 hardreset clears status", rd, 41'h7071);
    dmi_rsp_valid = 1; dmi_rsp_data = 32'h0BAD0BAD; cyc(1); dmi_rsp_valid = 0;
    fr(6'h11, 41, '0, rd);
    fr(6'h11, 41, '0, rd);
    chk("R8 late rsp ignored", rd, dmi(7'h05, 32'hCAFEF00D, 2'd0));

    // R9 error response, R8 dmireset
    fr(6'h11, 41, dmi(7'h02, 32'h0, 2'd1), rd);
    dmi_req_ready = 1; cyc(1); dmi_req_ready = 0;
    dmi_rsp_valid = 1; dmi_rsp_data = 32'h00001234; dmi_rsp_status = 2'd2; cyc(1);
    dmi_rsp_valid = 0; dmi_rsp_status = 2'd0;
    fr(6'h11, 41, '0, rd);
    chk("R9 error status", rd, dmi(7'h02, 32'h00001234, 2'd2));
    fr(6'h11, 41, dmi(7'h03, 32'h9, 2'd2), rd);
    chk("R9 no req while sticky", 41'(dmi_req_valid), 41'd0);
    fr(6'h10, 32, '0, rd);
    fr(6'h10, 32, 41'(1 << 16), rd);
    chk("R3 dtmcs shows error", rd, 41'h7871);
    fr(6'h10, 32, '0, rd);
    chk("R8 dmireset clears", rd, 41'h7071);

    // R4 length mismatch ignored
    frame(6'h01, 32, 7'd31, '0, 4, rd);
    fr(6'h10, 32, '0, rd);
    chk("R4 bad frame ignored", rd, 41'h7071);

    // R12 width mismatch: IR moves, no write
    fr(6'h11, 10, 41'h2, rd);
    chk("R12 no req on short frame", 41'(dmi_req_valid), 41'd0);
    fr(6'h11, 41, '0, rd);
    chk("R12 IR moved to dmi", rd, dmi(7'h02, 32'h00001234, 2'd0));

    // R5 other chain ignored
    frame(6'h01, 32, 7'd32, '0, 3, rd);
    frame(6'h11, 41, 7'd41, dmi(7'h07, 32'h5, 2'd2), 3, rd);
    chk("R5 other chain no req", 41'(dmi_req_valid), 41'd0);
    fr(6'h11, 41, '0, rd);
    chk("R5 IR unchanged", rd, dmi(7'h02, 32'h00001234, 2'd0));

    // R10 outer reset
    usr_reset = 1; cyc(1); usr_reset = 0;
    fr(6'h10, 32, '0, rd);
    chk("R10 outer reset to idcode", rd & 41'hFFFFFFFF, 41'(ID));

    // R11 cpu reset follows request, debug state kept
    ndm_reset_req = 1; cyc(1);
    chk("R11 cpu reset asserted", 41'(cpu_rst_n), 41'd0);
    fr(6'h10, 32, '0, rd);
    chk("R11 debug kept in cpu reset", rd, 41'h7071);
    ndm_reset_req = 0; cyc(1);
    chk("R11 cpu reset released", 41'(cpu_rst_n), 41'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule